// File: doc/BRIEF.md
# Byte-Wide SPI Master with Two-Step Status Flags

This block is a byte-wide SPI master that a processor drives through three registers: control, status and data. A write to the data register, with the master enabled and no shift under way, sends that byte out on MOSI, most significant bit first, while the byte arriving on MISO is shifted in. SCK idles low and MISO is sampled on the rising edge. MOSI changes on the falling edge. The SCK half-period is a power-of-two number of system clocks, chosen in the control register. When the shift ends, the received byte can be read from the data register.

The status register carries three sticky flags: transfer done, write collision and mode fault. Each flag clears only through a two-step sequence. The first step is a status read made while the flag is set. The second step is a specific register access. A per-flag armed bit links the two steps, so a flag that sets after the status read is never lost. If the slave-select input is pulled low while the block is master, a mode fault is recorded, the master bit is dropped, and SCK and MOSI are released. A pin-direction input can switch off this check.

The register port is a plain single-cycle strobe interface with no back-pressure: a strobe is acted on in the cycle it is high, and read data is valid in that same cycle. There is no stream interface at this block's edge.

Top module: `spi_flagged_ctrl`

## Requirements
- R1: After reset, all three registers read as zero, `irq_o` is low, and `sck_oe_o` and `mosi_oe_o` are low.
- R2: Register select 0 is control, 1 is status and 2 is data. A transfer starts only when the data register is written while control bit 0 (master enable) is 1 and no transfer is running. A data write made with master enable at 0 is ignored, and a data read never starts a transfer.
- R3: Each transfer shifts 8 bits, MSB first. SCK idles low, and MISO is sampled on its rising edge. The SCK half-period is 2^rate system clocks, where rate is control bits [3:2], so a full transfer takes 16 x 2^rate clocks from the write edge to the flag. The received byte is then read from the data register.
- R4: Status bit 7 (transfer done) sets when the eighth SCK cycle ends. It clears only after a status read made while it is set, followed by a read or write of the data register.
- R5: A data write made during a transfer is discarded, and the byte being shifted is unchanged. Status bit 6 (write collision) sets. It clears after a status read made while it is set, followed by any data-register access.
- R6: `irq_o` is high exactly when control bit 1 (interrupt enable) is set and transfer done or mode fault is set. A write collision alone never raises it.
- R7: Status bit 4 (mode fault) sets when master enable is 1, `ss_n_i` is low and `ss_pin_out_i` is low. In the same edge, master enable is cleared and `sck_oe_o`/`mosi_oe_o` fall.
- R8: Mode fault clears only after a status read made while it is set, followed by a write to the control register. Data-register accesses do not clear it.
- R9: While `ss_pin_out_i` is high, a low `ss_n_i` records no mode fault, and master enable stays set.
- R10: Status bits 5 and 3..0 always read as zero, and writes to the status register have no effect.
- R11: If a flag was clear at the status read and sets afterwards, the next qualifying access leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_wr_i | input | 1 | Write strobe, one cycle |
| reg_rd_i | input | 1 | Read strobe, one cycle (triggers the clear-sequence side effects) |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register, combinational |
| sck_o | output | 1 | Serial clock |
| sck_oe_o | output | 1 | SCK output enable |
| mosi_o | output | 1 | Serial data out |
| mosi_oe_o | output | 1 | MOSI output enable |
| miso_i | input | 1 | Serial data in |
| ss_n_i | input | 1 | Slave-select input, active low |
| ss_pin_out_i | input | 1 | Slave-select pin direction is output; inhibits the mode-fault check |
| irq_o | output | 1 | Interrupt request |

## Verification
Transfers are run with complementary, all-ones, all-zeros and alternating byte pairs in the two directions. These patterns show bit-order errors, stuck lines and a missing final shift that a single pattern would hide. They are run at two clock rates, and the cycle count from the data write to the done flag is measured, which separates a divider off by one from a correct one. The clear sequences are tried in wrong orders (an access without the status read, a data access where a control write is needed) and in the right order. A status read taken before the flag sets tells the armed-bit logic apart from a plain "read then access" check. A colliding write in the middle of a shift must leave both the MOSI byte seen by a bench slave and the received byte intact.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;
  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_STAT = 2'd1,
    SEL_DATA = 2'd2
  } reg_sel_e;

  // status bit positions (software decodes these)
  localparam int ST_DONE_BIT  = 7;
  localparam int ST_COLL_BIT  = 6;
  localparam int ST_FAULT_BIT = 4;

  // control field positions
  localparam int CT_MASTER_BIT = 0;
  localparam int CT_IRQEN_BIT  = 1;
  localparam int CT_RATE_LSB   = 2;

  // flag vector indices
  localparam int FL_DONE  = 0;
  localparam int FL_COLL  = 1;
  localparam int FL_FAULT = 2;
  localparam int FL_NUM   = 3;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div #(
  parameter int RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  output logic              tick_o
);
  localparam int DIV_W = 1 << RATE_W;

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] half_m1;

  assign half_m1 = (DIV_W'(1) << rate_i) - DIV_W'(1);
  assign tick_o  = run_i && (cnt_q == half_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!run_i || tick_o)  cnt_q <= '0;
    else                        cnt_q <= cnt_q + DIV_W'(1);
  end
endmodule

// File: rtl/spi_shift_core.sv
module spi_shift_core #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] load_i,
  input  logic              tick_i,
  input  logic              abort_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              sck_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int CNT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic              busy_q, sck_q, samp_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] sh_q, rx_q;
  logic [DATA_W-1:0] sh_next;

  assign sh_next = {sh_q[DATA_W-2:0], samp_q};
  assign done_o  = busy_q && tick_i && sck_q && (cnt_q == LAST) && !abort_i;
  assign busy_o  = busy_q;
  assign sck_o   = sck_q;
  assign mosi_o  = sh_q[DATA_W-1];
  assign rx_o    = rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      samp_q <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rx_q   <= '0;
    end else if (abort_i) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      sck_q  <= 1'b0;
      cnt_q  <= '0;
      sh_q   <= load_i;
    end else if (busy_q && tick_i) begin
      if (!sck_q) begin
        sck_q  <= 1'b1;
        samp_q <= miso_i;
      end else begin
        sck_q <= 1'b0;
        sh_q  <= sh_next;
        cnt_q <= cnt_q + CNT_W'(1);
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          rx_q   <= sh_next;
        end
      end
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit #(
  parameter int N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] acc_i,
  input  logic         stat_rd_i,
  output logic [N-1:0] flag_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q, arm_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (set_i[g]) begin
        flag_q <= 1'b1;
        arm_q  <= 1'b0;
      end else if (arm_q && acc_i[g]) begin
        flag_q <= 1'b0;
        arm_q  <= 1'b0;
      end else if (stat_rd_i) begin
        arm_q <= flag_q;
      end
    end
    assign flag_o[g] = flag_q;
  end
endmodule

// File: rtl/spi_flagged_ctrl.sv
module spi_flagged_ctrl
  import spi_flag_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RATE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic              reg_rd_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              sck_o,
  output logic              sck_oe_o,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  input  logic              ss_n_i,
  input  logic              ss_pin_out_i,
  output logic              irq_o
);
  logic              master_q, irqen_q;
  logic [RATE_W-1:0] rate_q;
  logic              sel_ctrl, sel_stat, sel_data;
  logic              ctrl_wr, stat_rd, data_wr, data_acc;
  logic              busy, done, tick, start, coll, fault;
  logic [FL_NUM-1:0] set_v, acc_v, flags;
  logic              spif, wcol, modf;
  logic [DATA_W-1:0] rx_byte, stat_word, ctrl_word;

  assign sel_ctrl = reg_sel_i == SEL_CTRL;
  assign sel_stat = reg_sel_i == SEL_STAT;
  assign sel_data = reg_sel_i == SEL_DATA;
  assign ctrl_wr  = reg_wr_i && sel_ctrl;
  assign stat_rd  = reg_rd_i && sel_stat;
  assign data_wr  = reg_wr_i && sel_data;
  assign data_acc = (reg_wr_i || reg_rd_i) && sel_data;

  assign fault = master_q && !ss_n_i && !ss_pin_out_i;
  assign start = data_wr && master_q && !busy && !fault;
  assign coll  = data_wr && busy;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      master_q <= 1'b0;
      irqen_q  <= 1'b0;
      rate_q   <= '0;
    end else begin
      if (ctrl_wr) begin
        master_q <= reg_wdata_i[CT_MASTER_BIT];
        irqen_q  <= reg_wdata_i[CT_IRQEN_BIT];
        rate_q   <= reg_wdata_i[CT_RATE_LSB +: RATE_W];
      end
      if (fault) master_q <= 1'b0;
    end
  end

  spi_clk_div #(.RATE_W(RATE_W)) div_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (busy),
    .rate_i(rate_q),
    .tick_o(tick)
  );

  spi_shift_core #(.DATA_W(DATA_W)) core_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(start),
    .load_i (reg_wdata_i),
    .tick_i (tick),
    .abort_i(fault),
    .miso_i (miso_i),
    .busy_o (busy),
    .sck_o  (sck_o),
    .mosi_o (mosi_o),
    .done_o (done),
    .rx_o   (rx_byte)
  );

  always_comb begin
    set_v           = '0;
    acc_v           = '0;
    set_v[FL_DONE]  = done;
    set_v[FL_COLL]  = coll;
    set_v[FL_FAULT] = fault;
    acc_v[FL_DONE]  = data_acc;
    acc_v[FL_COLL]  = data_acc;
    acc_v[FL_FAULT] = ctrl_wr;
  end

  spi_flag_unit #(.N(FL_NUM)) flags_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (set_v),
    .acc_i    (acc_v),
    .stat_rd_i(stat_rd),
    .flag_o   (flags)
  );

  assign spif = flags[FL_DONE];
  assign wcol = flags[FL_COLL];
  assign modf = flags[FL_FAULT];

  always_comb begin
    stat_word               = '0;
    stat_word[ST_DONE_BIT]  = spif;
    stat_word[ST_COLL_BIT]  = wcol;
    stat_word[ST_FAULT_BIT] = modf;
    ctrl_word                           = '0;
    ctrl_word[CT_MASTER_BIT]            = master_q;
    ctrl_word[CT_IRQEN_BIT]             = irqen_q;
    ctrl_word[CT_RATE_LSB +: RATE_W]    = rate_q;
  end

  always_comb begin
    unique case (reg_sel_i)
      SEL_CTRL: reg_rdata_o = ctrl_word;
      SEL_STAT: reg_rdata_o = stat_word;
      SEL_DATA: reg_rdata_o = rx_byte;
      default:  reg_rdata_o = '0;
    endcase
  end

  assign sck_oe_o  = master_q;
  assign mosi_oe_o = master_q;
  assign irq_o     = irqen_q && (spif || modf);
endmodule

// File: rtl/spi_flagged_ctrl_chk.sv
module spi_flagged_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [1:0]        reg_sel_i,
  input logic              reg_wr_i,
  input logic              reg_rd_i,
  input logic [DATA_W-1:0] reg_rdata_o,
  input logic              sck_oe_o,
  input logic              mosi_oe_o,
  input logic              ss_pin_out_i,
  input logic              irq_o,
  input logic              busy,
  input logic              spif,
  input logic              wcol,
  input logic              modf
);
  logic data_wr, data_acc, ctrl_wr;
  assign data_wr  = reg_wr_i && (reg_sel_i == 2'd2);
  assign data_acc = (reg_wr_i || reg_rd_i) && (reg_sel_i == 2'd2);
  assign ctrl_wr  = reg_wr_i && (reg_sel_i == 2'd0);

  a_r2_no_start_without_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && !data_wr) |=> !busy);

  a_r4_done_clears_on_data_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spif) |-> $past(data_acc));

  a_r5_collision_flagged: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy) |=> wcol);

  a_r6_collision_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wcol && !spif && !modf) |-> !irq_o);

  a_r7_fault_releases_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(modf) |-> (!sck_oe_o && !mosi_oe_o));

  a_r8_fault_clears_on_ctrl_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(modf) |-> $past(ctrl_wr));

  a_r9_fault_inhibited: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!modf && ss_pin_out_i) |=> !modf);

  a_r10_status_spare_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_sel_i == 2'd1) |-> ((reg_rdata_o & 8'h2F) == 8'h00));
endmodule

bind spi_flagged_ctrl spi_flagged_ctrl_chk #(.DATA_W(DATA_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_sel_i   (reg_sel_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .sck_oe_o    (sck_oe_o),
  .mosi_oe_o   (mosi_oe_o),
  .ss_pin_out_i(ss_pin_out_i),
  .irq_o       (irq_o),
  .busy        (busy),
  .spif        (spif),
  .wcol        (wcol),
  .modf        (modf)
);

// File: tb/spi_flagged_ctrl_tb_top.sv
module spi_flagged_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam logic [1:0] S_CTRL = 2'd0, S_STAT = 2'd1, S_DATA = 2'd2;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       rst_n, wr, rd, miso, ss_n, ss_out;
  logic [1:0] sel;
  logic [7:0] wdata, rdata;
  logic       sck, sck_oe, mosi, mosi_oe, irq;

  spi_flagged_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .reg_sel_i(sel), .reg_wr_i(wr), .reg_rd_i(rd),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .sck_o(sck), .sck_oe_o(sck_oe),
    .mosi_o(mosi), .mosi_oe_o(mosi_oe), .miso_i(miso), .ss_n_i(ss_n),
    .ss_pin_out_i(ss_out), .irq_o(irq)
  );

  int n_tests = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // slave model
  logic [7:0] sl_tx = 8'h00, mosi_cap = 8'h00;
  logic [2:0] sidx = 3'd0;
  int sck_edges = 0;
  assign miso = sl_tx[3'd7 - sidx];
  always @(negedge sck) sidx = sidx + 3'd1;
  always @(posedge sck) begin
    mosi_cap = {mosi_cap[6:0], mosi};
    sck_edges++;
  end

  // scoreboard
  typedef struct { logic [7:0] mo; logic [7:0] mi; } item_t;
  item_t exp_q[$];
  logic [7:0] act_rx, act_mo;
  event got_ev;

  initial forever begin
    @(got_ev);
    if (exp_q.size() == 0) chk(1'b0, "R3", "unexpected result", 0, 0);
    else begin
      item_t it;
      it = exp_q.pop_front();
      chk(act_mo == it.mo, "R3", "MOSI byte", act_mo, it.mo);
      chk(act_rx == it.mi, "R3", "received byte", act_rx, it.mi);
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] d);
    @(negedge clk);
    sel = s; rd = 1'b1;
    #(CLK_PERIOD/4);
    d = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic wait_irq(output int cycles);
    cycles = 0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      cycles++;
      if (irq) break;
    end
  endtask

  task automatic begin_xfer(input logic [7:0] tx, input logic [7:0] sl);
    item_t it;
    sidx = 3'd0; sl_tx = sl;
    it.mo = tx; it.mi = sl;
    exp_q.push_back(it);
    reg_write(S_DATA, tx);
  endtask

  // full transfer with proper clear; returns cycle count to irq
  task automatic xfer(input logic [7:0] tx, input logic [7:0] sl, output int cyc);
    logic [7:0] s;
    begin_xfer(tx, sl);
    wait_irq(cyc);
    reg_read(S_STAT, s);
    chk(s[7] == 1'b1, "R4", "done flag after transfer", s, 8'h80);
    reg_read(S_DATA, act_rx);
    act_mo = mosi_cap;
    ->got_ev;
    reg_read(S_STAT, s);
    chk(s == 8'h00, "R4", "done flag cleared by status+data", s, 8'h00);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] s;
    int cyc, e0;
    rst_n = 1'b0; wr = 1'b0; rd = 1'b0; sel = S_CTRL; wdata = 8'h00;
    ss_n = 1'b1; ss_out = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    sel = S_STAT; #1;
    chk(rdata == 8'h00, "R1", "status after reset", rdata, 0);
    sel = S_CTRL; #1;
    chk(rdata == 8'h00, "R1", "control after reset", rdata, 0);
    sel = S_DATA; #1;
    chk(rdata == 8'h00, "R1", "data after reset", rdata, 0);
    chk(!irq && !sck_oe && !mosi_oe, "R1", "irq/oe after reset",
        {irq, sck_oe, mosi_oe}, 0);

    // R2 data write with master off is ignored
    e0 = sck_edges;
    reg_write(S_DATA, 8'h55);
    repeat (40) @(negedge clk);
    reg_read(S_STAT, s);
    chk(sck_edges == e0 && s == 8'h00, "R2", "write with master off",
        sck_edges - e0, 0);

    reg_write(S_CTRL, 8'h03);
    chk(sck_oe && mosi_oe, "R7", "bus driven when master on", {sck_oe, mosi_oe}, 3);

    // R2 data read never starts
    e0 = sck_edges;
    reg_read(S_DATA, s);
    repeat (40) @(negedge clk);
    chk(sck_edges == e0 && !irq, "R2", "data read starts nothing", sck_edges - e0, 0);

    // R3 transfers, rate 0
    xfer(8'hA5, 8'h3C, cyc);
    chk(cyc == 16, "R3", "cycles at rate 0", cyc, 16);
    xfer(8'hFF, 8'h00, cyc);
    xfer(8'h00, 8'hFF, cyc);
    reg_write(S_CTRL, 8'h0B);
    xfer(8'h81, 8'h7E, cyc);
    chk(cyc == 64, "R3", "cycles at rate 2", cyc, 64);
    reg_write(S_CTRL, 8'h03);

    // R4 data access without status read does not clear
    begin_xfer(8'h5A, 8'hC3);
    wait_irq(cyc);
    reg_read(S_DATA, act_rx);
    act_mo = mosi_cap;
    ->got_ev;
    reg_read(S_STAT, s);
    chk(s[7] == 1'b1, "R4", "done kept without prior status read", s, 8'h80);
    reg_read(S_DATA, s);
    reg_read(S_STAT, s);
    chk(s[7] == 1'b0, "R4", "done cleared by status then data", s, 0);

    // R5/R6 write collision
    begin_xfer(8'hC3, 8'h5A);
    repeat (3) @(negedge clk);
    reg_write(S_DATA, 8'h11);
    sel = S_STAT; #1;
    chk(rdata == 8'h40, "R5", "collision flag set", rdata, 8'h40);
    chk(!irq, "R6", "no irq from collision", irq, 0);
    wait_irq(cyc);
    reg_read(S_STAT, s);
    chk(s == 8'hC0, "R5", "done and collision set", s, 8'hC0);
    reg_read(S_DATA, act_rx);
    act_mo = mosi_cap;
    ->got_ev;
    reg_read(S_STAT, s);
    chk(s == 8'h00, "R5", "collision cleared by status+data", s, 0);

    // R11 flag that sets after the status read survives
    begin_xfer(8'h3C, 8'hA5);
    reg_read(S_STAT, s);
    wait_irq(cyc);
    reg_read(S_DATA, act_rx);
    act_mo = mosi_cap;
    ->got_ev;
    reg_read(S_STAT, s);
    chk(s[7] == 1'b1, "R11", "late-set flag not lost", s, 8'h80);
    reg_read(S_DATA, s);
    chk(!irq, "R6", "irq low after clear", irq, 0);

    // R7 mode fault
    ss_n = 1'b0;
    repeat (2) @(negedge clk);
    ss_n = 1'b1;
    sel = S_STAT; #1;
    chk(rdata == 8'h10, "R7", "mode fault set", rdata, 8'h10);
    sel = S_CTRL; #1;
    chk(rdata[0] == 1'b0, "R7", "master cleared", rdata, 8'h02);
    chk(!sck_oe && !mosi_oe, "R7", "bus released", {sck_oe, mosi_oe}, 0);
    chk(irq, "R6", "irq from mode fault", irq, 1);

    // R8 clear sequence
    reg_write(S_CTRL, 8'h02);
    reg_read(S_STAT, s);
    chk(s[4] == 1'b1, "R8", "ctrl write without status read", s, 8'h10);
    reg_read(S_DATA, s);
    reg_read(S_STAT, s);
    chk(s[4] == 1'b1, "R8", "data access does not clear fault", s, 8'h10);
    reg_write(S_CTRL, 8'h03);
    reg_read(S_STAT, s);
    chk(s == 8'h00 && !irq, "R8", "fault cleared by status+ctrl write", s, 0);

    // R9 inhibit
    ss_out = 1'b1; ss_n = 1'b0;
    repeat (4) @(negedge clk);
    sel = S_STAT; #1;
    chk(rdata == 8'h00, "R9", "no fault when pin is output", rdata, 0);
    sel = S_CTRL; #1;
    chk(rdata[0] == 1'b1, "R9", "master kept", rdata, 8'h03);
    ss_n = 1'b1; ss_out = 1'b0;

    // R10 status writes ignored
    reg_write(S_STAT, 8'hFF);
    sel = S_STAT; #1;
    chk(rdata == 8'h00 && !irq, "R10", "status write no effect", rdata, 0);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R3", "scoreboard drained", exp_q.size(), 0);
    finish_run();
  end
endmodule